// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in packed BCD: a tenths-of-a-second digit, seconds, minutes, and a 12-hour hour field with a PM flag. It is paced by a slow mains-frequency tick. That tick is brought into the clock domain and edge-detected. A prescaler then divides it by five or six, so a 50 Hz or a 60 Hz source gives one tenth per expiry. A second register set of the same format holds an alarm time. When counting lands the time exactly on the alarm, the block emits a one-cycle interrupt pulse.

Software sees four byte-wide fields at indices 0 to 3. Writes go to the time or to the alarm, depending on an external select bit. Reads are combinational from the read index. Reading the hour field freezes what reads return, so that a multi-byte read is coherent while the clock keeps running underneath. Reading the tenths field releases the hold. Bus decoding and interrupt masking belong to the surrounding logic.

Top module: `tod_clock`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every time field, every alarm field and the prescaler are zero. rd_data reads 0 for each index, and alarm_irq is low.
- R2: tick_in passes through a two-flop synchroniser and a rising-edge detector. A rising edge of tick_in that is first sampled at clock edge k acts on the prescaler at edge k+2. A level held high for many cycles counts as one tick.
- R3: The prescaler holds the number of ticks still to skip. When a tick arrives and the count is zero, the time advances by one tenth and the count reloads to 4 (rate_sel=0, divide by 5) or to 5 (rate_sel=1, divide by 6). Otherwise the tick decrements the count. Because the count starts at zero, the first tick after reset advances the time.
- R4: Tenths (index 0) counts 0 to 9, and its wrap carries into seconds. Seconds (index 1) and minutes (index 2) are BCD 00 to 59: the low digit wraps after 9 into the high digit, and the high digit wraps after 5 into the next field.
- R5: Hours (index 3) keeps the PM flag in bit 7 and a BCD hour in bits 4:0. When the incremented hour exceeds 0x11, the hour becomes 0 and the PM flag inverts (0x11 goes to 0x00 with the flag toggled).
- R6: A write (wr_en high) with alarm_sel=0 loads the time field selected by wr_idx. With alarm_sel=1 it loads the alarm field instead, and the readable time is left unchanged.
- R7: Written bytes are masked per field: 0x0F for tenths, 0x7F for seconds and minutes, 0x9F for hours.
- R8: A time write on the same cycle as an advance wins: the written field takes the written value, the other fields keep their values, and that advance is lost. The prescaler still reloads.
- R9: A read (rd_en high) of index 3 while not frozen captures all four time fields. From the next cycle on, rd_data shows the captured copy until a read of index 0, which still returns the copy and releases the hold from the next cycle. Counting continues while frozen.
- R10: alarm_irq is high for exactly one cycle, in the cycle after the clock edge at which an advance makes all four time fields equal the four alarm fields. Writes never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Asynchronous mains-rate tick |
| rate_sel | input | 1 | 0: divide ticks by 5, 1: divide by 6 |
| alarm_sel | input | 1 | Steers writes to the alarm set when high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 2 | Field index for writes (0 tenths, 1 sec, 2 min, 3 hour) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, drives the hold/release side effects |
| rd_idx | input | 2 | Field index for reads |
| rd_data | output | 8 | Read data, combinational from rd_idx |
| alarm_irq | output | 1 | One-cycle alarm match pulse |

## Verification
The bench targets the carry chain at its edges. It drives 11:59:59.9 in both halves of the day and expects 00:00:00.0 with the PM flag inverted. A wrong hour compare would show 12 or leave the flag alone. The bench sets a write on exactly the cycle of an advance, where a design that let the advance win would show a tenth too many. It also runs a long freeze while ticks arrive: a hold that recaptured or released early would show moving digits. Finally, it holds tick_in high for many cycles, and it switches between divide-by-5 and divide-by-6. Here a level-sensitive tick path or a misloaded prescaler would show up as extra or missing tenths. Alarm pulses are counted across a rollover, so a compare that ignored the advance strobe would pulse repeatedly.

// File: rtl/tod_pkg.sv
// Shared constants, types and BCD step functions for the time-of-day clock.
// Assumes fields are byte wide and stored in their masked form.
package tod_pkg;

    localparam int FIELDS = 4;
    localparam logic [1:0] IDX_TENTHS = 2'd0;
    localparam logic [1:0] IDX_SEC    = 2'd1;
    localparam logic [1:0] IDX_MIN    = 2'd2;
    localparam logic [1:0] IDX_HOUR   = 2'd3;

    typedef logic [FIELDS-1:0][7:0] tod_regs_t;

    typedef struct packed {
        logic       wrap;
        logic [7:0] val;
    } step_t;

    // Write mask of each field.
    function automatic logic [7:0] field_mask(input logic [1:0] idx);
        case (idx)
            IDX_TENTHS: return 8'h0F;
            IDX_SEC:    return 8'h7F;
            IDX_MIN:    return 8'h7F;
            default:    return 8'h9F;
        endcase
    endfunction

    // One step of the tenths digit; wraps after 9.
    function automatic step_t step_tenths(input logic [3:0] v);
        logic [4:0] lo;
        step_t      r;
        lo = {1'b0, v} + 5'd1;
        if (lo > 5'd9) r = '{wrap: 1'b1, val: 8'h00};
        else           r = '{wrap: 1'b0, val: {3'b000, lo}};
        return r;
    endfunction

    // One step of a two-digit 00..59 BCD field.
    function automatic step_t step_sexa(input logic [6:0] v);
        logic [4:0] lo;
        logic [3:0] hi;
        step_t      r;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[6:4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 4'd1;
        end
        if (hi > 4'd5) r = '{wrap: 1'b1, val: 8'h00};
        else           r = '{wrap: 1'b0, val: {1'b0, hi[2:0], lo[3:0]}};
        return r;
    endfunction

    // One step of the 12-hour field; input is {pm, hour[4:0]}.
    function automatic logic [7:0] step_hour(input logic [5:0] v);
        logic       pm;
        logic [4:0] lo;
        logic [1:0] hi;
        logic [5:0] h;
        pm = v[5];
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 2'd1;
        end
        h = {hi, lo[3:0]};
        if (h > 6'h11) return {~pm, 7'b0};
        return {pm, 2'b00, hi[0], lo[3:0]};
    endfunction

endpackage

// File: rtl/tod_tick_sync.sv
// Brings the asynchronous mains tick into the clock domain and turns each
// rising edge into a single-cycle pulse.
// Assumes tick_in stays at each level for at least one clock cycle.
module tod_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw tick through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign tick_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;

    // R2: an edge yields one pulse, never two in a row.
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/tod_prescaler.sv
// Divides tick pulses by DIV_LOW or DIV_HIGH and issues the advance strobe.
// Assumes tick pulses are single-cycle; the count starts at zero.
module tod_prescaler #(
    parameter int DIV_LOW  = 5,
    parameter int DIV_HIGH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_pulse,
    input  logic rate_sel,
    output logic advance
);
    localparam int RELOAD_LO = DIV_LOW - 1;
    localparam int RELOAD_HI = DIV_HIGH - 1;
    localparam int CW        = $clog2(DIV_HIGH);

    logic [CW-1:0] presc_q;

    assign advance = tick_pulse && (presc_q == '0);

    // Count down per tick; reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (tick_pulse) begin
            if (presc_q == '0) presc_q <= rate_sel ? CW'(RELOAD_HI) : CW'(RELOAD_LO);
            else               presc_q <= presc_q - 1'b1;
        end
    end

    // R3: the count never leaves its range.
    p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= CW'(RELOAD_HI));

    // R3: expiry reloads according to the selected rate.
    p_presc_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (presc_q == ($past(rate_sel) ? CW'(RELOAD_HI) : CW'(RELOAD_LO))));

endmodule

// File: rtl/tod_counter.sv
// Holds the time and alarm fields, runs the BCD carry chain on each advance,
// applies masked writes and raises the alarm pulse on a counted match.
// Assumes at most one write per cycle and advance strobes several cycles apart.
module tod_counter
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       alarm_sel,
    input  logic       wr_en,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    output tod_regs_t  time_q,
    output logic       alarm_irq
);
    tod_regs_t  alarm_q;
    tod_regs_t  nxt;
    step_t      st_ten, st_sec, st_min;
    logic [7:0] hr_nxt;
    logic       time_wr;
    logic       alarm_wr;
    logic [7:0] wr_masked;

    assign time_wr   = wr_en && !alarm_sel;
    assign alarm_wr  = wr_en && alarm_sel;
    assign wr_masked = wr_data & field_mask(wr_idx);

    // Carry chain: next time value if this cycle advances.
    always_comb begin
        st_ten = step_tenths(time_q[IDX_TENTHS][3:0]);
        st_sec = step_sexa(time_q[IDX_SEC][6:0]);
        st_min = step_sexa(time_q[IDX_MIN][6:0]);
        hr_nxt = step_hour({time_q[IDX_HOUR][7], time_q[IDX_HOUR][4:0]});
        nxt             = time_q;
        nxt[IDX_TENTHS] = st_ten.val;
        if (st_ten.wrap) begin
            nxt[IDX_SEC] = st_sec.val;
            if (st_sec.wrap) begin
                nxt[IDX_MIN] = st_min.val;
                if (st_min.wrap) nxt[IDX_HOUR] = hr_nxt;
            end
        end
    end

    // Time fields: a write takes priority over the advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (time_wr) time_q[wr_idx] <= wr_masked;
        else if (advance) time_q <= nxt;
    end

    // Alarm fields: written only when steered there.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '0;
        else if (alarm_wr) alarm_q[wr_idx] <= wr_masked;
    end

    // Alarm pulse: compare only on a counted update.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_irq <= 1'b0;
        else        alarm_irq <= advance && !time_wr && (nxt == alarm_q);
    end

    // R4: tenths at 9 wraps to 0 on an advance.
    p_tenths_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !time_wr && time_q[IDX_TENTHS][3:0] == 4'd9) |=> (time_q[IDX_TENTHS] == 8'h00));

    // R5: 11:59:59.9 rolls to hour zero with the PM flag inverted.
    p_pm_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !time_wr && time_q[IDX_HOUR][4:0] == 5'h11 && time_q[IDX_MIN] == 8'h59
         && time_q[IDX_SEC] == 8'h59 && time_q[IDX_TENTHS] == 8'h09)
        |=> (time_q[IDX_HOUR][4:0] == 5'h00 && time_q[IDX_HOUR][7] != $past(time_q[IDX_HOUR][7])));

    // R10: the pulse follows an advance and lasts one cycle.
    p_irq_from_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> $past(advance));
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |=> !alarm_irq);

endmodule

// File: rtl/tod_read_hold.sv
// Read path: returns live time, or a copy captured by an hour read and kept
// until a tenths read releases it.
// Assumes one read index per cycle; read data is combinational.
module tod_read_hold
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tod_regs_t  live,
    input  logic       rd_en,
    input  logic [1:0] rd_idx,
    output logic [7:0] rd_data
);
    tod_regs_t snap_q;
    logic      frozen_q;

    // Capture on an hour read, release on a tenths read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q   <= '0;
            frozen_q <= 1'b0;
        end else if (rd_en && rd_idx == IDX_HOUR && !frozen_q) begin
            snap_q   <= live;
            frozen_q <= 1'b1;
        end else if (rd_en && rd_idx == IDX_TENTHS) begin
            frozen_q <= 1'b0;
        end
    end

    assign rd_data = frozen_q ? snap_q[rd_idx] : live[rd_idx];

    // R9: while held and not released, the copy does not move.
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !(rd_en && rd_idx == IDX_TENTHS)) |=> (frozen_q && $stable(snap_q)));

endmodule

// File: rtl/tod_clock.sv
// Top of the BCD time-of-day clock: tick synchroniser, prescaler, counter
// with alarm, and read hold path.
// Assumes a single clock; tick_in may be asynchronous to it.
module tod_clock
    import tod_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOW     = 5,
    parameter int DIV_HIGH    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       rate_sel,
    input  logic       alarm_sel,
    input  logic       wr_en,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [1:0] rd_idx,
    output logic [7:0] rd_data,
    output logic       alarm_irq
);
    logic      tick_pulse;
    logic      advance;
    tod_regs_t time_q;

    tod_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_pulse(tick_pulse)
    );

    tod_prescaler #(.DIV_LOW(DIV_LOW), .DIV_HIGH(DIV_HIGH)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse),
        .rate_sel(rate_sel), .advance(advance)
    );

    tod_counter u_count (
        .clk(clk), .rst_n(rst_n), .advance(advance), .alarm_sel(alarm_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .time_q(time_q), .alarm_irq(alarm_irq)
    );

    tod_read_hold u_read (
        .clk(clk), .rst_n(rst_n), .live(time_q), .rd_en(rd_en),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // R6: an alarm-steered write leaves the live time untouched.
    p_alarm_wr_no_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alarm_sel && !advance) |=> $stable(time_q));

endmodule

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       rate_sel = 1'b0;
    logic       alarm_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_idx = 2'd0;
    logic [7:0] rd_data;
    logic       alarm_irq;

    always #5 clk = ~clk;

    tod_clock u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .rate_sel(rate_sel),
        .alarm_sel(alarm_sel), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    // Reference model state
    int m_t[4], m_a[4], m_snap[4];
    int m_presc;
    bit m_frz, m_irq, s1, s2, prv;

    int    compared = 0, mismatched = 0, cyc_n = 0, irq_seen = 0;
    bit    cmp_en = 0, hold_idx = 0, finished = 0;
    string cur_req = "R1";

    function automatic int bcd(int v);   return (v / 10) * 16 + v % 10; endfunction
    function automatic int unbcd(int v); return (v / 16) * 10 + v % 16; endfunction
    function automatic int mask_of(int idx);
        return idx == 0 ? 'h0F : (idx == 3 ? 'h9F : 'h7F);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc_n, act, exp);
        end
    endtask

    function automatic void model_advance();
        int s, m, h, pm;
        if (m_t[0] < 9) begin m_t[0]++; return; end
        m_t[0] = 0;
        s = unbcd(m_t[1]) + 1;
        if (s < 60) begin m_t[1] = bcd(s); return; end
        m_t[1] = 0;
        m = unbcd(m_t[2]) + 1;
        if (m < 60) begin m_t[2] = bcd(m); return; end
        m_t[2] = 0;
        pm = m_t[3] & 'h80;
        h  = unbcd(m_t[3] & 'h1F) + 1;
        if (h > 11) m_t[3] = pm ^ 'h80;
        else        m_t[3] = pm | bcd(h);
    endfunction

    function automatic void model_step();
        bit edge_seen, adv, match;
        int told[4];
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_t[i] = 0; m_a[i] = 0; m_snap[i] = 0; end
            m_presc = 0; m_frz = 0; m_irq = 0; s1 = 0; s2 = 0; prv = 0;
            return;
        end
        edge_seen = s2 && !prv;
        prv = s2; s2 = s1; s1 = tick_in;
        adv = 0;
        if (edge_seen) begin
            if (m_presc != 0) m_presc--;
            else begin m_presc = rate_sel ? 5 : 4; adv = 1; end
        end
        for (int i = 0; i < 4; i++) told[i] = m_t[i];
        m_irq = 0;
        if (wr_en && !alarm_sel) m_t[wr_idx] = wr_data & mask_of(wr_idx);
        else if (adv) begin
            model_advance();
            match = 1;
            for (int i = 0; i < 4; i++) if (m_t[i] != m_a[i]) match = 0;
            m_irq = match;
        end
        if (wr_en && alarm_sel) m_a[wr_idx] = wr_data & mask_of(wr_idx);
        if (rd_en && rd_idx == 2'd3 && !m_frz) begin
            for (int i = 0; i < 4; i++) m_snap[i] = told[i];
            m_frz = 1;
        end else if (rd_en && rd_idx == 2'd0) m_frz = 0;
    endfunction

    task automatic cyc();
        if (!hold_idx) rd_idx = 2'(cyc_n % 4);
        #1;
        if (cmp_en) begin
            check(cur_req, rd_data, m_frz ? m_snap[rd_idx] : m_t[rd_idx], "rd_data");
            check(cur_req, alarm_irq, m_irq, "alarm_irq");
            if (alarm_irq) irq_seen++;
        end
        model_step();
        @(negedge clk);
        cyc_n++;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_in = 1'b1; repeat (3) cyc();
            tick_in = 1'b0; repeat (3) cyc();
        end
    endtask

    task automatic wr(bit sel, int idx, int d);
        alarm_sel = sel; wr_en = 1'b1; wr_idx = 2'(idx); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0; alarm_sel = 1'b0;
    endtask

    task automatic rd(int idx);
        hold_idx = 1'b1; rd_en = 1'b1; rd_idx = 2'(idx);
        cyc();
        rd_en = 1'b0; hold_idx = 1'b0;
    endtask

    task automatic set_time(int t0, int t1, int t2, int t3);
        wr(0, 0, t0); wr(0, 1, t1); wr(0, 2, t2); wr(0, 3, t3);
    endtask

    function automatic int legal(int idx);
        case (idx)
            0: return $urandom % 10;
            1, 2: return bcd($urandom % 60);
            default: return (($urandom % 2) << 7) | bcd($urandom % 12);
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog R1: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        cyc();
        cmp_en = 1'b1;
        repeat (2) cyc();
        rst_n = 1'b1;
        hold_idx = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i); #1;
            check("R1", rd_data, 0, "reset field");
            check("R1", alarm_irq, 0, "reset irq");
            cyc();
        end
        hold_idx = 1'b0;

        // R3: both division ratios, first tick advances
        cur_req = "R3";
        rate_sel = 1'b0; ticks(12);
        rate_sel = 1'b1; ticks(14);

        // R2: long high level counts once
        cur_req = "R2";
        tick_in = 1'b1; repeat (40) cyc();
        tick_in = 1'b0; repeat (10) cyc();
        ticks(3);

        // R7: masked writes
        cur_req = "R7";
        rate_sel = 1'b0;
        wr(0, 2, 'hFF);
        hold_idx = 1'b1; rd_idx = 2'd2; #1;
        check("R7", rd_data, 'h7F, "minute mask");
        cyc(); hold_idx = 1'b0;
        set_time('hF9, 'hD9, 'h59, 'hF1);
        hold_idx = 1'b1; rd_idx = 2'd3; #1;
        check("R7", rd_data, 'h91, "hour mask");
        cyc(); hold_idx = 1'b0;

        // R6: alarm writes do not disturb time
        cur_req = "R6";
        wr(1, 0, 0); wr(1, 1, 0); wr(1, 2, 0); wr(1, 3, 0);
        repeat (4) cyc();

        // R5 / R10: PM 11:59:59.9 rolls to AM 0, alarm matches once
        cur_req = "R5";
        irq_seen = 0;
        ticks(8);
        check("R10", irq_seen, 1, "alarm pulse count");
        set_time('h09, 'h59, 'h59, 'h11);
        irq_seen = 0;
        ticks(8);
        check("R10", irq_seen, 0, "no pulse without match");

        // R4: digit carries
        cur_req = "R4";
        set_time('h09, 'h59, 'h09, 'h05);
        ticks(14);
        set_time('h09, 'h09, 'h59, 'h09);
        ticks(8);

        // R9: freeze while counting
        cur_req = "R9";
        rd(3);
        ticks(15);
        rd(1); rd(3);
        ticks(3);
        rd(0);
        repeat (6) cyc();

        // R8: write collides with advance
        cur_req = "R8";
        begin
            bit done = 0;
            for (int k = 0; k < 400 && !done; k++) begin
                tick_in = ((k / 3) % 2) == 0;
                if (s2 && !prv && m_presc == 0) begin
                    wr(0, 0, 5);
                    done = 1;
                end else cyc();
            end
            check("R8", done, 1, "collision reached");
        end
        tick_in = 1'b0;
        hold_idx = 1'b1; rd_idx = 2'd0; #1;
        check("R8", rd_data, 5, "write wins");
        cyc(); hold_idx = 1'b0;

        // Mixed traffic
        cur_req = "R6";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 3 == 0) tick_in = ~tick_in;
            if (k % 500 == 0) rate_sel = $urandom % 2;
            if ($urandom % 16 == 0) begin
                int idx = $urandom % 4;
                alarm_sel = $urandom % 2; wr_en = 1'b1; wr_idx = 2'(idx); wr_data = 8'(legal(idx));
            end
            if ($urandom % 12 == 0) begin
                hold_idx = 1'b1; rd_en = 1'b1; rd_idx = 2'($urandom % 4);
            end
            cyc();
            wr_en = 1'b0; alarm_sel = 1'b0; rd_en = 1'b0; hold_idx = 1'b0;
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule